// File: doc/BRIEF.md
# Dual-Rank Bus Register with Serial Shifter

This block holds two registers of equal width. The bus rank faces a bidirectional data port. The shift rank is a serial shifter that takes one bit in at its low end and presents its top bit at a serial output. On each rising clock edge, a set of active-low control inputs decides what happens. The bus rank can capture the port, a word can move down from the bus rank into the shift rank, or a word can move up from the shift rank into the bus rank. The shift rank can also shift by one place, and both ranks can be cleared together. Every control input is a "hold" line: driving it low enables its operation and driving it high holds that operation off.

The bidirectional port is split into three signals: an input word, an output word that always carries the bus rank, and an output-enable for an external three-state driver. Releasing the port stops only the driving. Transfers, shifts and clears continue as before. Several instances can be chained into a wider shifter by connecting each serial output to the next serial input.

Top module: `dual_rank_shifter`

## Requirements
- R1: While `rst_n` is low, both ranks are zero, `port_oe` is 0, `port_out` is 0 and `ser_out` is 0. This holds without a clock edge.
- R2: `port_oe` is 1 exactly when `drive_hold` is low and `load_hold` is high. A low `load_hold` overrides a low `drive_hold`. `port_out` always equals the bus rank.
- R3: When `load_hold` is low and no clear applies, the bus rank takes `port_in` at the edge. This has priority over a transfer up.
- R4: When `down_hold` is low and no clear applies, the shift rank takes the bus rank's value from before the edge. This has priority over shifting.
- R5: When `up_hold` is low, `load_hold` is high and no clear applies, the bus rank takes the shift rank's value from before the edge.
- R6: When `shift_hold` is low and `down_hold` is high, the shift rank becomes {shift rank[W-2:0], `ser_in`}. `ser_out` is the shift rank's bit W-1, with no register on the way, so that instances can be chained.
- R7: A clear applies when `up_hold`, `down_hold` and `shift_hold` are all low on the same edge. Both ranks then become zero, whatever `load_hold` is.
- R8: When `up_hold` and `down_hold` are low and `shift_hold` is high, the two ranks exchange their values from before the edge. If `load_hold` is also low, the bus rank takes `port_in` instead.
- R9: With all five hold inputs high, neither rank changes. The value of `drive_hold` has no effect on the next state of either rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | W | Word read from the bidirectional port |
| port_out | output | W | Bus rank value for the port driver |
| port_oe | output | 1 | Port driver enable, 1 = drive |
| drive_hold | input | 1 | Active-low output enable for the port |
| load_hold | input | 1 | Active-low enable for loading the bus rank from the port |
| up_hold | input | 1 | Active-low enable for moving the shift rank into the bus rank |
| down_hold | input | 1 | Active-low enable for moving the bus rank into the shift rank |
| shift_hold | input | 1 | Active-low enable for a serial shift |
| ser_in | input | 1 | Serial data into bit 0 of the shift rank |
| ser_out | output | 1 | Serial data from bit W-1 of the shift rank |

## Verification
The assertions assume that every control input and `ser_in` is a known 0 or 1 at each rising edge once reset is released. They also assume that `port_in` is known whenever a load applies. The bench changes inputs only at falling edges and draws every value from the fixed-seed generator, so no unknown value ever reaches a sampled edge. The hold lines are low with roughly one-in-three odds each. This makes clears, exchanges and load-over-transfer collisions common in the random phase. Directed sequences cover those same collisions deliberately.

// File: rtl/dual_rank_shifter.sv
module dual_rank_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_in,
  output logic [W-1:0] port_out,
  output logic         port_oe,
  input  logic         drive_hold,
  input  logic         load_hold,
  input  logic         up_hold,
  input  logic         down_hold,
  input  logic         shift_hold,
  input  logic         ser_in,
  output logic         ser_out
);

  logic [W-1:0] rank_a, rank_b;
  logic         do_load, do_up, do_down, do_shift, do_clear;

  assign do_load  = ~load_hold;
  assign do_up    = ~up_hold;
  assign do_down  = ~down_hold;
  assign do_shift = ~shift_hold;
  assign do_clear = do_up & do_down & do_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_a <= '0;
    end else if (do_clear) begin
      rank_a <= '0;
    end else if (do_load) begin
      rank_a <= port_in;
    end else if (do_up) begin
      rank_a <= rank_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_b <= '0;
    end else if (do_clear) begin
      rank_b <= '0;
    end else if (do_down) begin
      rank_b <= rank_a;
    end else if (do_shift) begin
      rank_b <= {rank_b[W-2:0], ser_in};
    end
  end

  assign port_out = rank_a;
  assign port_oe  = rst_n & ~drive_hold & load_hold;
  assign ser_out  = rank_b[W-1];

  assert_input_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_hold |-> !port_oe);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hold && !do_clear) |=> port_out == $past(port_in));

  assert_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!down_hold && !do_clear) |=> rank_b == $past(port_out));

  assert_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_hold && load_hold && !do_clear) |=> port_out == $past(rank_b));

  assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_hold && down_hold) |=> rank_b == {$past(rank_b[W-2:0]), $past(ser_in)});

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_hold && !down_hold && !shift_hold) |=> (port_out == '0 && ser_out == 1'b0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hold && up_hold && down_hold && shift_hold) |=> ($stable(port_out) && $stable(rank_b)));

endmodule

// File: tb/test_dual_rank_shifter.sv
`timescale 1ns/1ps
module test_dual_rank_shifter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] port_in = '0;
  logic [W-1:0] port_out;
  logic         port_oe;
  logic         drive_hold = 1'b1, load_hold = 1'b1, up_hold = 1'b1;
  logic         down_hold = 1'b1, shift_hold = 1'b1, ser_in = 1'b0;
  logic         ser_out;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] ma = '0, mb = '0;

  always #10 clk = ~clk;

  dual_rank_shifter #(.W(W)) i_dual_rank_shifter (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .port_out(port_out),
    .port_oe(port_oe), .drive_hold(drive_hold), .load_hold(load_hold),
    .up_hold(up_hold), .down_hold(down_hold), .shift_hold(shift_hold),
    .ser_in(ser_in), .ser_out(ser_out)
  );

  function automatic logic [W-1:0] next_a(logic [W-1:0] a, logic [W-1:0] b,
      logic [W-1:0] p, logic ld, logic up, logic dn, logic sh);
    if (!up && !dn && !sh) return '0;
    if (!ld) return p;
    if (!up) return b;
    return a;
  endfunction

  function automatic logic [W-1:0] next_b(logic [W-1:0] a, logic [W-1:0] b,
      logic si, logic up, logic dn, logic sh);
    if (!up && !dn && !sh) return '0;
    if (!dn) return a;
    if (!sh) return {b[W-2:0], si};
    return b;
  endfunction

  function automatic string op_tag(logic ld, logic up, logic dn, logic sh);
    if (!up && !dn && !sh) return "R7";
    if (!up && !dn) return "R8";
    if (!ld) return "R3";
    if (!dn) return "R4";
    if (!up) return "R5";
    if (!sh) return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_comb();
    check("R2", "port_oe", {{(W-1){1'b0}}, port_oe},
          {{(W-1){1'b0}}, (!drive_hold && load_hold)});
    check("R2", "port_out", port_out, ma);
    check("R6", "ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, mb[W-1]});
  endtask

  task automatic step(logic dr, logic ld, logic up, logic dn, logic sh,
                      logic si, logic [W-1:0] p);
    string tag;
    drive_hold = dr; load_hold = ld; up_hold = up; down_hold = dn;
    shift_hold = sh; ser_in = si; port_in = p;
    #1;
    check_comb();
    tag = op_tag(ld, up, dn, sh);
    @(posedge clk);
    ma = next_a(ma, mb, p, ld, up, dn, sh);
    mb = next_b(ma == ma ? i_hold_a : ma, mb, si, up, dn, sh);
    @(negedge clk);
    check(tag, "rank_a", port_out, ma);
    check(tag, "ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, mb[W-1]});
  endtask

  logic [W-1:0] i_hold_a;
  always @(negedge clk) i_hold_a = ma;

  task automatic read_b(string tag, logic [W-1:0] exp);
    logic [W-1:0] got = '0;
    for (int k = W - 1; k >= 0; k--) begin
      got[k] = ser_out;
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    end
    check(tag, "shifted word", got, exp);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #5;
    check("R1", "rank_a in reset", port_out, '0);
    check("R1", "port_oe in reset", {{(W-1){1'b0}}, port_oe}, '0);
    drive_hold = 1'b0;
    #1;
    check("R1", "port_oe forced off", {{(W-1){1'b0}}, port_oe}, '0);
    check("R1", "ser_out in reset", {{(W-1){1'b0}}, ser_out}, '0);
    drive_hold = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5);
    check("R3", "load with input over output", port_out, 8'hA5);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    read_b("R4", 8'hA5);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C);
    for (int k = 0; k < W; k++)
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, k[0], '0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R8", "exchange to A", port_out, 8'h55);
    read_b("R8", 8'h3C);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h81);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h7E);
    check("R8", "load wins over exchange", port_out, 8'h7E);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF);
    check("R7", "clear over load", port_out, 8'h00);
    read_b("R7", 8'h00);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hC3);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h11);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h22);
    check("R9", "idle keeps A", port_out, 8'hC3);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h99);
    check("R3", "load wins over up", port_out, 8'h99);

    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 3) != 0,
           ($urandom % 3) != 0, ($urandom % 3) != 0, $urandom % 2,
           W'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule